// File: doc/BRIEF.md
# Bus Initiator Transaction Sequencer

This block is the initiator half of a multiplexed 32-bit parallel bus. A local client hands it one command: an address, a 4-bit bus command code, a direction and a burst length. The sequencer then asks the arbiter for the bus and waits for the grant. It drives a single address cycle and then walks through the data phases. It holds its own ready line asserted, and it inserts wait cycles until the target's ready line is low in the same cycle. The cycle strobe is held low while more phases follow and is released in the final phase. The ready line is released one clock later.

The target can end the burst early with a stop request, with or without moving data in that cycle. If no target claims the address within a fixed number of clocks, the sequencer ends the transaction on its own. This is a master abort. In every case the client gets a one-cycle done pulse, a count of the phases that actually moved data, and an abort flag. Write data is taken straight from the client, which advances to the next word on each take pulse. Read data is handed out in the cycle the target supplies it.

All bus control lines are active low. Address and data share `ad_out` and `ad_in`, and `ad_oe` tells the pad logic when the initiator drives.

Top module: `bm_seq`

## Requirements
- R1: After reset the request, cycle strobe and initiator ready outputs are high, `ad_oe`, `busy`, `done` and `aborted` are low.
- R2: A command accepted while idle pulls `bus_req_n` low in the next cycle and holds it low until `bus_gnt_n` is sampled low. The cycle strobe falls on that same edge and the request is released with it.
- R3: The address cycle lasts one clock, with `cyc_n` low, `ad_oe` high, `ad_out` equal to the command address and `cbe_out` equal to the command code.
- R4: In every data cycle `cyc_n` is low while further phases remain and high while the final phase is pending. A length of 0 is handled as a length of 1.
- R5: `ini_rdy_n` goes low in the first cycle after the address cycle. A phase completes only in a cycle where `tgt_rdy_n` is also low, and cycles without it transfer nothing.
- R6: On a write, `ad_oe` is high, `ad_out` equals `wr_data`, `cbe_out` is 4'b0000 (all bytes enabled) and `wr_take` is high exactly in completing cycles. On a read, `ad_oe` is low and `rd_valid` is high exactly in completing cycles, with `rd_data` equal to `ad_in`.
- R7: After the final phase completes, `ini_rdy_n` is high in the next cycle. `done` is high for that one cycle only and `xfer_count` equals the length.
- R8: A stop request sampled together with target ready counts that phase. The next cycle has `cyc_n` high with `ini_rdy_n` still low, and the cycle after that has `ini_rdy_n` high, with `done` high and `xfer_count` equal to the phases moved.
- R9: A stop request sampled without target ready transfers nothing in that cycle and ends the burst by the same two-step release.
- R10: If `tgt_sel_n` is not sampled low on any of the first DSEL_LIMIT edges after the address cycle, `cyc_n` rises after the last of those edges and `ini_rdy_n` rises one cycle later, with `done` and `aborted` both high and `xfer_count` 0.
- R11: `cmd_valid` is ignored while a transaction is in progress. No new request follows the end of the transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Start a transaction (sampled while idle) |
| cmd_addr | input | 32 | Transaction address |
| cmd_code | input | 4 | Bus command code for the address cycle |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_len | input | LEN_W | Number of data phases (0 means 1) |
| wr_data | input | 32 | Current write word |
| wr_take | output | 1 | Current write word consumed this cycle |
| rd_data | output | 32 | Read word |
| rd_valid | output | 1 | Read word valid this cycle |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle end-of-transaction pulse |
| aborted | output | 1 | With done: no target claimed the address |
| xfer_count | output | LEN_W | Phases completed in the last transaction |
| bus_req_n | output | 1 | Bus request to the arbiter |
| bus_gnt_n | input | 1 | Bus grant from the arbiter |
| ad_in | input | 32 | Shared address/data lines, input side |
| ad_out | output | 32 | Shared address/data lines, output side |
| ad_oe | output | 1 | Drive enable for ad_out |
| cbe_out | output | 4 | Command in the address cycle, byte enables in data cycles |
| cyc_n | output | 1 | Cycle strobe |
| ini_rdy_n | output | 1 | Initiator ready |
| tgt_rdy_n | input | 1 | Target ready |
| tgt_stop_n | input | 1 | Target stop request |
| tgt_sel_n | input | 1 | Target has claimed the address |

## Verification
The case that needs care is a stop request and a target ready in the same data cycle. The phase must still be counted and its data passed on, and the strobe must still come down ahead of the ready line. The bench sweeps the stop position over every phase of several burst lengths, both with and without data in the stop cycle. The position includes the final phase, where a stop with data must look exactly like a normal end. The partial count and the release order are judged against values the bench derives from the stop position. A second collision is the claim deadline against a late target claim. The bench sets the claim delay on both sides of DSEL_LIMIT and expects an abort exactly when the delay exceeds it.

// File: rtl/bm_pkg.sv
package bm_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_ADDR,
    ST_DATA,
    ST_DRAIN
  } bm_state_t;

  localparam logic [3:0] BE_ALL_ON = 4'b0000;

endpackage

// File: rtl/bm_beat_ctr.sv
module bm_beat_ctr #(
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [LEN_W-1:0] len,
  input  logic             beat,
  output logic             last_now,
  output logic             last_next,
  output logic [LEN_W-1:0] count
);

  logic [LEN_W-1:0] rem;

  function automatic logic [LEN_W-1:0] eff_len(input logic [LEN_W-1:0] l);
    return (l == '0) ? LEN_W'(1) : l;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem   <= '0;
      count <= '0;
    end else if (load) begin
      rem   <= eff_len(len);
      count <= '0;
    end else if (beat) begin
      rem   <= rem - 1'b1;
      count <= count + 1'b1;
    end
  end

  assign last_now  = (rem == LEN_W'(1));
  assign last_next = (rem == LEN_W'(2));

  AST_BEAT_WITH_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
    beat |-> rem != '0);  // R7

endmodule

// File: rtl/bm_dsel_watch.sv
module bm_dsel_watch #(
  parameter int LIMIT = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic active,
  input  logic sel_n,
  output logic expired
);

  localparam int AGE_W = $clog2(LIMIT + 1);

  logic [AGE_W-1:0] age;
  logic             seen;

  function automatic logic at_deadline(input logic [AGE_W-1:0] a);
    return a == AGE_W'(LIMIT - 1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      age  <= '0;
      seen <= 1'b0;
    end else if (arm) begin
      age  <= '0;
      seen <= 1'b0;
    end else if (active) begin
      seen <= seen | ~sel_n;
      if (age != AGE_W'(LIMIT)) age <= age + 1'b1;
    end
  end

  assign expired = active & ~seen & sel_n & at_deadline(age);

  AST_NO_EXPIRE_AFTER_CLAIM: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !sel_n) |=> !expired);  // R10

endmodule

// File: rtl/bm_seq.sv
module bm_seq #(
  parameter int LEN_W      = 4,
  parameter int DSEL_LIMIT = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [31:0]      cmd_addr,
  input  logic [3:0]       cmd_code,
  input  logic             cmd_write,
  input  logic [LEN_W-1:0] cmd_len,
  input  logic [31:0]      wr_data,
  output logic             wr_take,
  output logic [31:0]      rd_data,
  output logic             rd_valid,
  output logic             busy,
  output logic             done,
  output logic             aborted,
  output logic [LEN_W-1:0] xfer_count,
  output logic             bus_req_n,
  input  logic             bus_gnt_n,
  input  logic [31:0]      ad_in,
  output logic [31:0]      ad_out,
  output logic             ad_oe,
  output logic [3:0]       cbe_out,
  output logic             cyc_n,
  output logic             ini_rdy_n,
  input  logic             tgt_rdy_n,
  input  logic             tgt_stop_n,
  input  logic             tgt_sel_n
);
  import bm_pkg::*;

  bm_state_t st;
  logic [31:0] addr_q;
  logic [3:0]  code_q;
  logic        write_q;
  logic        abort_pend;

  // named internal events
  logic accept, in_addr, in_data, in_drain;
  logic beat, stop_req, expired, last_now, last_next;

  assign accept   = (st == ST_IDLE) & cmd_valid;
  assign in_addr  = (st == ST_ADDR);
  assign in_data  = (st == ST_DATA);
  assign in_drain = (st == ST_DRAIN);
  assign beat     = in_data & ~ini_rdy_n & ~tgt_rdy_n;
  assign stop_req = in_data & ~tgt_stop_n;

  bm_beat_ctr #(.LEN_W(LEN_W)) u_beats (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept),
    .len       (cmd_len),
    .beat      (beat),
    .last_now  (last_now),
    .last_next (last_next),
    .count     (xfer_count)
  );

  bm_dsel_watch #(.LIMIT(DSEL_LIMIT)) u_dsel (
    .clk     (clk),
    .rst_n   (rst_n),
    .arm     (in_addr),
    .active  (in_data),
    .sel_n   (tgt_sel_n),
    .expired (expired)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      addr_q     <= '0;
      code_q     <= '0;
      write_q    <= 1'b0;
      abort_pend <= 1'b0;
      bus_req_n  <= 1'b1;
      cyc_n      <= 1'b1;
      ini_rdy_n  <= 1'b1;
      done       <= 1'b0;
      aborted    <= 1'b0;
    end else begin
      done    <= 1'b0;
      aborted <= 1'b0;
      unique case (st)
        ST_IDLE: if (cmd_valid) begin
          addr_q     <= cmd_addr;
          code_q     <= cmd_code;
          write_q    <= cmd_write;
          abort_pend <= 1'b0;
          bus_req_n  <= 1'b0;
          st         <= ST_REQ;
        end
        ST_REQ: if (!bus_gnt_n) begin
          bus_req_n <= 1'b1;
          cyc_n     <= 1'b0;
          st        <= ST_ADDR;
        end
        ST_ADDR: begin
          ini_rdy_n <= 1'b0;
          cyc_n     <= last_now;
          st        <= ST_DATA;
        end
        ST_DATA: begin
          if (beat && last_now) begin
            ini_rdy_n <= 1'b1;
            done      <= 1'b1;
            st        <= ST_IDLE;
          end else if (stop_req) begin
            cyc_n <= 1'b1;
            st    <= ST_DRAIN;
          end else if (beat) begin
            cyc_n <= last_next;
          end else if (expired) begin
            cyc_n      <= 1'b1;
            abort_pend <= 1'b1;
            st         <= ST_DRAIN;
          end
        end
        ST_DRAIN: begin
          ini_rdy_n <= 1'b1;
          done      <= 1'b1;
          aborted   <= abort_pend;
          st        <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign busy     = (st != ST_IDLE);
  assign ad_oe    = in_addr | (write_q & (in_data | in_drain));
  assign ad_out   = in_addr ? addr_q : wr_data;
  assign cbe_out  = in_addr ? code_q : BE_ALL_ON;
  assign wr_take  = beat & write_q;
  assign rd_valid = beat & ~write_q;
  assign rd_data  = ad_in;

  AST_ADDR_AFTER_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cyc_n) |-> !$past(bus_gnt_n));  // R2
  AST_REQ_ONLY_OFF_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_req_n |-> (cyc_n && ini_rdy_n));  // R2
  AST_RDY_AFTER_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cyc_n) |=> !ini_rdy_n);  // R5
  AST_STROBE_RISE_UNDER_RDY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cyc_n) |-> !ini_rdy_n);  // R4
  AST_RDY_RISE_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ini_rdy_n) |-> (cyc_n && $past(cyc_n)));  // R7
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);  // R7
  AST_ABORT_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    aborted |-> done);  // R10

endmodule

// File: tb/bm_seq_tb.sv
module bm_seq_tb;
  localparam int LEN_W = 4;
  localparam int LIM   = 5;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, cmd_valid, cmd_write, wr_take, rd_valid, busy, done, aborted;
  logic [31:0] cmd_addr, wr_data, rd_data, ad_in, ad_out;
  logic [3:0]  cmd_code, cbe_out;
  logic [LEN_W-1:0] cmd_len, xfer_count;
  logic bus_req_n, bus_gnt_n, ad_oe, cyc_n, ini_rdy_n, tgt_rdy_n, tgt_stop_n, tgt_sel_n;

  int checks = 0;
  int errors = 0;
  bit ended  = 0;

  bm_seq #(.LEN_W(LEN_W), .DSEL_LIMIT(LIM)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_addr(cmd_addr),
    .cmd_code(cmd_code), .cmd_write(cmd_write), .cmd_len(cmd_len),
    .wr_data(wr_data), .wr_take(wr_take), .rd_data(rd_data), .rd_valid(rd_valid),
    .busy(busy), .done(done), .aborted(aborted), .xfer_count(xfer_count),
    .bus_req_n(bus_req_n), .bus_gnt_n(bus_gnt_n), .ad_in(ad_in), .ad_out(ad_out),
    .ad_oe(ad_oe), .cbe_out(cbe_out), .cyc_n(cyc_n), .ini_rdy_n(ini_rdy_n),
    .tgt_rdy_n(tgt_rdy_n), .tgt_stop_n(tgt_stop_n), .tgt_sel_n(tgt_sel_n)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] wpat(input logic [31:0] a, input int k);
    return (a ^ 32'h5A5A_0000) + 32'(k) * 32'h0101_0101;
  endfunction
  function automatic logic [31:0] rpat(input logic [31:0] a, input int k);
    return ~a + 32'(k) * 32'h0011_2233;
  endfunction

  task automatic tgt_idle();
    tgt_rdy_n = 1'b1; tgt_stop_n = 1'b1; tgt_sel_n = 1'b1; bus_gnt_n = 1'b1;
  endtask

  // stop_at < 0: no stop; ddly == 0 or > LIM: nobody claims
  task automatic run(input logic [31:0] a, input bit wr, input int len, input int gdly,
                     input int ddly, input int wt, input int stop_at, input bit sdata,
                     input bit noisy);
    int eff, exp_n, g, j, ph, w;
    bit exp_ab, fin, prev_final, prev_drain, pend_drain, take, sel;
    logic [3:0] code;
    eff    = (len == 0) ? 1 : len;
    exp_ab = (ddly == 0) || (ddly > LIM);
    if (exp_ab) exp_n = 0;
    else if (stop_at >= 0 && stop_at < eff) exp_n = sdata ? stop_at + 1 : stop_at;
    else exp_n = eff;
    code = wr ? 4'h7 : 4'h6;
    g = 0; j = -1; ph = 0; w = 0;
    fin = 0; prev_final = 0; prev_drain = 0; pend_drain = 0;

    @(negedge clk);
    chk(busy == 1'b0, "R11", "busy before command", 32'(busy), 0);
    cmd_addr = a; cmd_code = code; cmd_write = wr; cmd_len = LEN_W'(len);
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(bus_req_n == 1'b0, "R2", "request after accept", 32'(bus_req_n), 0);

    for (int c = 0; c < 300 && !fin; c++) begin
      if (j < 0) begin
        if (!cyc_n) begin
          chk(ad_out == a, "R3", "address", ad_out, a);
          chk(cbe_out == code && ad_oe, "R3", "command/oe", {27'd0, ad_oe, cbe_out}, {27'd0, 1'b1, code});
          chk(bus_req_n == 1'b1 && ini_rdy_n == 1'b1, "R2", "req released, rdy idle",
              {30'd0, bus_req_n, ini_rdy_n}, 32'h3);
          j = 0;
          bus_gnt_n = 1'b1;
        end else begin
          chk(bus_req_n == 1'b0, "R2", "request held", 32'(bus_req_n), 0);
          bus_gnt_n = (g >= gdly) ? 1'b0 : 1'b1;
          g++;
        end
      end else begin
        j++;
        if (ini_rdy_n) begin
          chk(prev_final || prev_drain, "R7", "ready released too early", 32'(j), 0);
          chk(done == 1'b1, "R7", "done pulse", 32'(done), 1);
          chk(xfer_count == LEN_W'(exp_n), "R8", "phase count", 32'(xfer_count), 32'(exp_n));
          chk(aborted == exp_ab, "R10", "abort flag", 32'(aborted), 32'(exp_ab));
          chk(cyc_n == 1'b1, "R7", "strobe idle at end", 32'(cyc_n), 1);
          fin = 1;
        end else begin
          if (j == 1) chk(ini_rdy_n == 1'b0, "R5", "ready after address", 32'(ini_rdy_n), 0);
          chk(!prev_final, "R7", "ready held after final phase", 32'(ini_rdy_n), 1);
          chk(!prev_drain, "R8", "ready held after strobe release", 32'(ini_rdy_n), 1);
          prev_final = 0; prev_drain = 0;
          wr_data = wpat(a, ph);
          ad_in   = rpat(a, ph);
          cmd_valid = noisy;
          if (pend_drain) begin
            chk(cyc_n == 1'b1, "R9", "strobe released after stop", 32'(cyc_n), 1);
            tgt_rdy_n = 1'b1;
            pend_drain = 0; prev_drain = 1;
          end else if (exp_ab && j == LIM + 1) begin
            chk(cyc_n == 1'b1, "R10", "strobe released at deadline", 32'(cyc_n), 1);
            tgt_rdy_n = 1'b1;
            prev_drain = 1;
          end else begin
            chk(cyc_n == (ph == eff - 1), "R4", "strobe vs remaining phases", 32'(cyc_n), 32'(ph == eff - 1));
            sel = (ddly > 0) && (j >= ddly);
            tgt_sel_n = ~sel;
            tgt_rdy_n = 1'b1; tgt_stop_n = 1'b1; take = 0;
            if (sel && w >= wt) begin
              if (stop_at == ph) begin
                tgt_stop_n = 1'b0;
                take = sdata;
                pend_drain = !(sdata && ph == eff - 1);
              end else take = 1;
            end else if (sel) w++;
            if (take) tgt_rdy_n = 1'b0;
            #1;
            if (take) begin
              if (wr) begin
                chk(wr_take && !rd_valid, "R6", "write take", {30'd0, wr_take, rd_valid}, 32'h2);
                chk(ad_out == wpat(a, ph), "R6", "write data", ad_out, wpat(a, ph));
                chk(ad_oe && cbe_out == 4'h0, "R6", "write oe/byte enables", {27'd0, ad_oe, cbe_out}, 32'h10);
              end else begin
                chk(rd_valid && !wr_take, "R6", "read valid", {30'd0, wr_take, rd_valid}, 32'h1);
                chk(rd_data == rpat(a, ph), "R6", "read data", rd_data, rpat(a, ph));
                chk(!ad_oe, "R6", "read oe off", 32'(ad_oe), 0);
              end
              if (ph == eff - 1 && !pend_drain) prev_final = 1;
              ph++; w = 0;
            end else begin
              chk(!wr_take && !rd_valid, "R5", "no transfer in wait", {30'd0, wr_take, rd_valid}, 0);
            end
          end
        end
      end
      if (!fin) @(negedge clk);
    end
    cmd_valid = 1'b0;
    tgt_idle();
    chk(fin, "R7", "transaction ended", 32'(fin), 1);
    @(negedge clk);
    chk(done == 1'b0, "R7", "done lasts one cycle", 32'(done), 0);
    chk(bus_req_n == 1'b1 && !busy, "R11", "no request from ignored command",
        {30'd0, bus_req_n, busy}, 32'h2);
  endtask

  initial begin
    #(4 * 150000);
    if (!ended) begin
      errors++;
      $display("FAIL watchdog run did not finish actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int lens[5] = '{0, 1, 2, 3, 6};
    int dls[3]  = '{1, 3, LIM};
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_addr = '0; cmd_code = '0; cmd_write = 1'b0;
    cmd_len = '0; wr_data = '0; ad_in = '0;
    tgt_idle();
    repeat (3) @(negedge clk);
    chk(bus_req_n && cyc_n && ini_rdy_n, "R1", "strobes high in reset",
        {29'd0, bus_req_n, cyc_n, ini_rdy_n}, 32'h7);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!ad_oe && !busy && !done && !aborted, "R1", "idle outputs after reset",
        {28'd0, ad_oe, busy, done, aborted}, 0);
    chk(bus_req_n && cyc_n && ini_rdy_n, "R1", "strobes high after reset",
        {29'd0, bus_req_n, cyc_n, ini_rdy_n}, 32'h7);

    // main sweep: direction x length x wait states x claim delay
    for (int wr = 0; wr < 2; wr++)
      for (int li = 0; li < 5; li++)
        for (int wt = 0; wt < 3; wt++)
          for (int di = 0; di < 3; di++)
            run(32'h1000_0000 + 32'(li * 64 + wt * 8 + di), wr[0], lens[li],
                (lens[li] + wt) % 3, dls[di], wt, -1, 1'b0, wt == 1);

    // stop at every phase, with and without data (R8, R9)
    for (int wr = 0; wr < 2; wr++)
      for (int len = 1; len < 5; len++)
        for (int s = 0; s < len; s++)
          for (int sd = 0; sd < 2; sd++)
            run(32'h2000_0000 + 32'(len * 16 + s * 2 + sd), wr[0], len, 1, 2, s % 2, s, sd[0], 1'b1);

    // master abort: late or missing claim (R10)
    for (int wr = 0; wr < 2; wr++) begin
      run(32'h3000_0010, wr[0], 1, 0, LIM + 1, 0, -1, 1'b0, 1'b0);
      run(32'h3000_0020, wr[0], 3, 2, 0, 0, -1, 1'b0, 1'b1);
      run(32'h3000_0030, wr[0], 4, 0, LIM + 1, 1, -1, 1'b0, 1'b0);
    end

    ended = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule